// File: doc/BRIEF.md
# Fan tachometer period counter

This block times the interval between successive pulses on a fan's tachometer line. It counts a free-running reference tick. The tachometer input is asynchronous, so it first passes through a synchronizer. A rising edge is then detected on the clean level. At each rising edge the elapsed count is published as a 16-bit result, and the counter starts over. A stalled fan, a missing signal, or an interval too long for 16 bits all show as the reserved value FFFFh.

Software reads the 16-bit result through an 8-bit port that has two byte addresses. Reading the low byte captures the high byte of the same sample. A read of the high byte that follows then returns that captured byte, so the two halves always match even when a new period lands between the reads. Both addresses are read-only. A write strobe is accepted and has no effect.

Top module: `fan_tach_period`

## Requirements
- R1: While reset is asserted and right after it, the read data output is 00h and the internal result holds FFFFh.
- R2: The tachometer input is synchronized through two flops. Only its 0-to-1 transitions are measured, and each transition yields a detection pulse exactly one clock long.
- R3: The published count equals the number of reference ticks seen from the clock of one detected edge, inclusive, up to the clock of the next detected edge, exclusive. For example, with a tick on every clock and a 100-clock period the result is 0064h.
- R4: The period counter stops at FFFFh instead of wrapping. It resumes from zero at the next detected edge.
- R5: When the period counter has reached FFFFh and no edge arrives, the published result becomes FFFFh without waiting for an edge. A stopped fan therefore reads FFFFh.
- R6: The published result stays FFFFh after reset until a first complete period has been measured. The first detected edge only starts the measurement.
- R7: A read at address 0 returns bits 7:0 of the current result and captures bits 15:8 of that same result.
- R8: A read at address 1 that follows an address-0 read returns the captured byte, even if the result has changed since. The capture is consumed by that read.
- R9: A read at address 1 with no capture pending returns bits 15:8 of the current result.
- R10: A write strobe changes neither the result nor the read data. If a read and a write are strobed in the same clock, the read is served.
- R11: Read data is registered. It appears on the clock after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference tick, synchronous to clk, one clock per tick |
| tach_in | input | 1 | Asynchronous tachometer pulse input |
| addr | input | 1 | Byte address: 0 selects the low byte, 1 selects the high byte |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| rd_data | output | 8 | Registered read data |

## Verification
A tachometer transition that the bench drives at a falling edge takes three rising edges to take effect: two for the synchronizer and one to update the counter. The result register changes on that third edge. Read data changes on the rising edge that follows the read strobe, so every directed read raises the strobe for one clock and samples at the next falling edge. The bench model runs the same per-clock timing on a sample queue and is compared with the read data on every falling edge. Directed checks wait whole periods before reading, so that the result has settled to the expected count.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [CNT_W-1:0]  count_t;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam count_t COUNT_MAX = '1;

  // next value of the period counter
  function automatic count_t count_next(input count_t cur, input logic tick,
                                        input logic edge_hit);
    if (edge_hit)
      return count_t'(tick);
    else if (cur == COUNT_MAX)
      return cur;
    else
      return cur + count_t'(tick);
  endfunction

  function automatic byte_t low_byte(input count_t v);
    return v[BYTE_W-1:0];
  endfunction

  function automatic byte_t high_byte(input count_t v);
    return v[CNT_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic rise_pulse
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], tach_in};
  end

  assign rise_pulse = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R2: a detected rise lasts a single clock
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);
endmodule

// File: rtl/tach_period_counter.sv
module tach_period_counter
  import fan_tach_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ref_tick,
  input  logic   rise_pulse,
  output count_t result
);
  count_t cnt_q;
  logic   armed_q;
  logic   at_max;

  assign at_max = (cnt_q == COUNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      result  <= COUNT_MAX;
    end else begin
      cnt_q <= count_next(cnt_q, ref_tick, rise_pulse);
      if (rise_pulse) begin
        armed_q <= 1'b1;
        if (armed_q) result <= cnt_q;
      end else if (at_max) begin
        result <= COUNT_MAX;
      end
    end
  end

  // R4: no wrap once saturated
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    at_max && !rise_pulse |=> cnt_q == COUNT_MAX);
  // R5: saturation is published without an edge
  a_r5_stall_flag: assert property (@(posedge clk) disable iff (!rst_n)
    at_max && !rise_pulse |=> result == COUNT_MAX);
  // R6: nothing but FFFFh before measurement starts
  a_r6_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> result == COUNT_MAX);
  // R3: an armed edge publishes the elapsed count
  a_r3_publish: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse && armed_q |=> result == $past(cnt_q));
endmodule

// File: rtl/tach_byte_latch.sv
module tach_byte_latch
  import fan_tach_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  count_t result,
  input  logic   addr,
  input  logic   rd_en,
  input  logic   wr_en,
  output byte_t  rd_data
);
  byte_t hold_hi_q;
  logic  hold_vld_q;
  logic  rd_lo, rd_hi;

  assign rd_lo = rd_en & ~addr;
  assign rd_hi = rd_en &  addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data    <= '0;
      hold_hi_q  <= '0;
      hold_vld_q <= 1'b0;
    end else if (rd_lo) begin
      rd_data    <= low_byte(result);
      hold_hi_q  <= high_byte(result);
      hold_vld_q <= 1'b1;
    end else if (rd_hi) begin
      rd_data    <= hold_vld_q ? hold_hi_q : high_byte(result);
      hold_vld_q <= 1'b0;
    end
  end

  // R8: a pending capture is returned on the high read
  a_r8_frozen_high: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && hold_vld_q |=> rd_data == $past(hold_hi_q));
  // R9: without a capture the live high byte is returned
  a_r9_live_high: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && !hold_vld_q |=> rd_data == $past(high_byte(result)));
  // R10: a lone write leaves the read data alone
  a_r10_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en |=> $stable(rd_data));
  // R11: read data holds between reads
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/fan_tach_period.sv
module fan_tach_period
  import fan_tach_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       tach_in,
  input  logic       addr,
  input  logic       rd_en,
  input  logic       wr_en,
  output logic [7:0] rd_data
);
  logic   rise_pulse;
  count_t result;

  tach_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .rise_pulse(rise_pulse)
  );

  tach_period_counter u_count (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .rise_pulse(rise_pulse), .result(result)
  );

  tach_byte_latch u_latch (
    .clk(clk), .rst_n(rst_n), .result(result), .addr(addr),
    .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data)
  );

  // R1: read data is clear straight after reset
  a_r1_reset_data: assert property (@(posedge clk)
    $rose(rst_n) |-> rd_data == 8'h00);
endmodule

// File: tb/tb_fan_tach_period.sv
module tb_fan_tach_period;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       tach_in = 1'b0;
  logic       addr = 1'b0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] rd_data;

  int errors = 0;
  int checks = 0;
  int tach_per = 0;
  int tick_div = 1;
  int cyc = 0;

  always #4 clk = ~clk;

  fan_tach_period dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // reference tick pattern
  always @(negedge clk) begin
    cyc++;
    ref_tick = (cyc % tick_div) == 0;
  end

  // tachometer generator
  initial begin
    forever begin
      if (tach_per == 0) begin
        tach_in = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = tach_per;
        tach_in = 1'b1;
        repeat (p / 2) @(negedge clk);
        tach_in = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  // behavioural reference model
  int hist[$] = '{0, 0, 0};
  int m_cnt = 0, m_res = 65535, m_armed = 0, m_hold = 0, m_hv = 0, m_rd = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_cnt = 0; m_res = 65535; m_armed = 0; m_hold = 0; m_hv = 0; m_rd = 0;
    end else begin
      bit seen;
      seen = (hist[1] == 1) && (hist[2] == 0);
      hist.push_front(int'(tach_in));
      void'(hist.pop_back());
      if (rd_en) begin
        if (!addr) begin
          m_rd = m_res % 256; m_hold = m_res / 256; m_hv = 1;
        end else begin
          m_rd = m_hv ? m_hold : m_res / 256; m_hv = 0;
        end
      end
      if (seen) begin
        if (m_armed) m_res = m_cnt;
        m_armed = 1;
        m_cnt = int'(ref_tick);
      end else if (m_cnt == 65535) begin
        m_res = 65535;
      end else if (ref_tick) begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk)
    if (rst_n) check("R11 model compare", int'(rd_data), m_rd);

  task automatic read_byte(input bit a, output int val);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    repeat (5) @(negedge clk);
    check("R1 reset rd_data", int'(rd_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data after reset", int'(rd_data), 0);
    read_byte(1'b0, v); check("R1 result low after reset", v, 8'hFF);
    read_byte(1'b1, v); check("R1 result high after reset", v, 8'hFF);

    tach_per = 100;
    repeat (40) @(negedge clk);
    read_byte(1'b0, v); check("R6 first edge only arms", v, 8'hFF);
    repeat (350) @(negedge clk);
    read_byte(1'b0, v); check("R3 low byte of 100 ticks", v, 8'h64);
    read_byte(1'b1, v); check("R8 high byte of 100 ticks", v, 8'h00);

    tick_div = 4;
    repeat (400) @(negedge clk);
    read_byte(1'b0, v); check("R3 sparse ticks low", v, 8'h19);
    read_byte(1'b1, v); check("R8 sparse ticks high", v, 8'h00);
    tick_div = 1;

    tach_per = 300;
    repeat (1000) @(negedge clk);
    read_byte(1'b0, v); check("R7 low of 300", v, 8'h2C);
    tach_per = 200;
    repeat (700) @(negedge clk);
    read_byte(1'b1, v); check("R8 frozen high", v, 8'h01);
    read_byte(1'b1, v); check("R9 live high", v, 8'h00);

    addr = 1'b0; wr_en = 1'b1;
    repeat (3) @(negedge clk);
    addr = 1'b1;
    repeat (3) @(negedge clk);
    wr_en = 1'b0;
    check("R10 rd_data after writes", int'(rd_data), 8'h00);
    read_byte(1'b0, v); check("R10 result unchanged low", v, 8'hC8);
    addr = 1'b1; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10 read served with write", int'(rd_data), 8'h00);

    tach_per = 0;
    repeat (66000) @(negedge clk);
    read_byte(1'b0, v); check("R5 stalled low", v, 8'hFF);
    read_byte(1'b1, v); check("R5 stalled high", v, 8'hFF);

    tach_per = 100;
    repeat (350) @(negedge clk);
    read_byte(1'b0, v); check("R4 restart after saturation low", v, 8'h64);
    read_byte(1'b1, v); check("R4 restart after saturation high", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule